// File: doc/BRIEF.md
# Protected Calendar Register Access Controller

This block stands between a bus-side register port and a real-time-clock core running on its own slow clock. It holds the protected calendar registers (time, date, control, prescaler), blocks writes to them until software has written a two-byte unlock key, and runs the handshake with the slow domain. That handshake covers entering and leaving initialization mode and refreshing the shadow copies of time and date that the bus reads. The calendar counter and any alarm logic sit outside and are not part of this block.

Software writes the first key and then the second key to the key register. It then sets the init request and polls until the init acknowledge flag is set. It loads time, date and prescaler, drops the init request, clears the resync flag and polls until the flag is set again. A write of any other key value closes the lock at once. Every flag that crosses between the two clocks passes through a chain of synchronizer flops.

Top module: `cal_access_guard`

## Requirements
- R1: The lock opens (`locked` low on the next bus cycle) only when a key write with low byte 0xCA is followed by a key write with low byte 0x53. The key register is word address 5, and the upper data bits are ignored.
- R2: A key write of any value other than the expected next key closes the lock on the next cycle. A write of 0xCA while open closes the lock and also counts as a first key.
- R3: A second key that is not directly preceded by a first key write, or a wrong byte between the two keys, restarts detection. The lock stays closed until 0xCA and then 0x53 are written.
- R4: While locked, writes to control (address 2), time (address 0), date (address 1), prescaler (address 4) and the init request bit are ignored. `prot_we` stays zero and the stored contents do not change.
- R5: The bit order of `prot_we` is {prescaler, control, date, time}. Time, date and prescaler writes are accepted only while unlocked with the init acknowledge flag set. Control writes need only the unlock.
- R6: Bit 7 of the status register (address 3) is the init request, and bit 6 is the init acknowledge (`init_mode`). The acknowledge follows a set or clear of the request after a synchronizer into the slow domain, one slow-clock register and a synchronizer back. It is never due in the cycle after the request.
- R7: A status write with bit 5 = 0 clears the resync flag (`sync_ok`, status bit 5) on the next cycle, whether the block is locked or not. The flag sets again after a full request/acknowledge round trip through the slow domain. Writing bit 5 = 1 has no effect on the flag.
- R8: Reads of time and date return shadow copies. These are loaded from the stored registers in the same cycle that the resync flag sets.
- R9: Status bit 4 (`cal_valid`) is 1 exactly when the stored date's year field (bits 23:16) is nonzero. It is 0 after reset.
- R10: After reset the block is locked, all flags are 0, the prescaler reads PRESC_RST, and the key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rtc_clk | input | 1 | Slow RTC clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low, both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| locked | output | 1 | Protected registers closed to writes |
| init_mode | output | 1 | Init acknowledge, synchronized to the bus clock |
| sync_ok | output | 1 | Shadow registers refreshed |
| cal_valid | output | 1 | Stored year field is nonzero |
| prot_we | output | 4 | Gated write enables of the protected registers |

## Verification
The lock state, the control and prescaler contents, `cal_valid` and the clearing of `sync_ok` are all due on the bus cycle after the write. The bench writes on a falling edge and samples at the next falling edge. `prot_we` is combinational and is sampled during the write cycle itself. The init acknowledge and the setting of `sync_ok` arrive after a cross-domain round trip whose length in bus cycles depends on the clock phase. The bench therefore polls each of these with a bound of 60 cycles, and it requires that the result is not yet present within the first 4 cycles.

// File: rtl/cal_acc_pkg.sv
package cal_acc_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;

  // word addresses
  localparam int A_TIME  = 0;
  localparam int A_DATE  = 1;
  localparam int A_CTRL  = 2;
  localparam int A_STAT  = 3;
  localparam int A_PRESC = 4;
  localparam int A_KEY   = 5;

  // protected register slots, in prot_we bit order
  localparam int NPROT   = 4;
  localparam int P_TIME  = 0;
  localparam int P_DATE  = 1;
  localparam int P_CTRL  = 2;
  localparam int P_PRESC = 3;

  // status bit positions, decoded by software
  localparam int B_INIT  = 7;
  localparam int B_INITF = 6;
  localparam int B_RSF   = 5;
  localparam int B_INITS = 4;

  // handshake lanes
  localparam int HS_INIT = 0;
  localparam int HS_RSF  = 1;
  localparam int HS_W    = 2;

  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_e;

  function automatic lock_e key_step(lock_e cur, logic [KEY_W-1:0] b);
    if (b == KEY_FIRST) return LK_HALF;
    if (b == KEY_SECOND && cur == LK_HALF) return LK_OPEN;
    return LK_IDLE;
  endfunction

  function automatic int prot_addr(int slot);
    case (slot)
      P_TIME:  return A_TIME;
      P_DATE:  return A_DATE;
      P_CTRL:  return A_CTRL;
      default: return A_PRESC;
    endcase
  endfunction

  function automatic logic prot_needs_init(int slot);
    return slot != P_CTRL;
  endfunction

  function automatic logic [7:0] year_of(logic [31:0] d);
    return d[23:16];
  endfunction

  function automatic logic [31:0] stat_word(logic init_r, logic initf,
                                            logic rsf, logic inits);
    logic [31:0] w;
    w = '0;
    w[B_INIT]  = init_r;
    w[B_INITF] = initf;
    w[B_RSF]   = rsf;
    w[B_INITS] = inits;
    return w;
  endfunction
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_key_lock.sv
module cal_key_lock
  import cal_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  output logic             locked
);
  lock_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= LK_IDLE;
    else if (key_wr) st_q <= key_step(st_q, key_byte);
  end

  assign locked = (st_q != LK_OPEN);
endmodule

// File: rtl/cal_rtc_echo.sv
module cal_rtc_echo #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         rtc_clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_bus,
  output logic [W-1:0] ack_rtc
);
  logic [W-1:0] req_s;

  cal_sync #(.W(W), .STAGES(STAGES)) u_in (
    .clk(rtc_clk), .rst_n(rst_n), .d(req_bus), .q(req_s)
  );

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) ack_rtc <= '0;
    else        ack_rtc <= req_s;
  end
endmodule

// File: rtl/cal_access_guard.sv
module cal_access_guard
  import cal_acc_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] PRESC_RST   = 32'h007F_00FF
) (
  input  logic              clk,
  input  logic              rtc_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              locked,
  output logic              init_mode,
  output logic              sync_ok,
  output logic              cal_valid,
  output logic [NPROT-1:0]  prot_we
);
  // decoded strobes
  logic key_wr, stat_wr, rsf_clear, rsf_done;
  logic init_req_q, rsf_q, rsf_pend_q, rsf_req_q;
  logic [HS_W-1:0] hs_req, hs_ack_rtc, hs_ack_bus;
  logic [DATA_W-1:0] prot_q [NPROT];
  logic [DATA_W-1:0] shadow_time, shadow_date;

  assign key_wr  = wr_en && (addr == ADDR_W'(A_KEY));
  assign stat_wr = wr_en && (addr == ADDR_W'(A_STAT));

  cal_key_lock u_lock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(wdata[KEY_W-1:0]), .locked(locked)
  );

  // request lanes into the slow domain, acknowledges back
  assign hs_req[HS_INIT] = init_req_q;
  assign hs_req[HS_RSF]  = rsf_req_q;

  cal_rtc_echo #(.W(HS_W), .STAGES(SYNC_STAGES)) u_echo (
    .rtc_clk(rtc_clk), .rst_n(rst_n), .req_bus(hs_req), .ack_rtc(hs_ack_rtc)
  );

  cal_sync #(.W(HS_W), .STAGES(SYNC_STAGES)) u_back (
    .clk(clk), .rst_n(rst_n), .d(hs_ack_rtc), .q(hs_ack_bus)
  );

  assign init_mode = hs_ack_bus[HS_INIT];

  // protected registers with gated write enables
  for (genvar g = 0; g < NPROT; g++) begin : g_prot
    localparam logic [DATA_W-1:0] RV =
      (g == P_PRESC) ? DATA_W'(PRESC_RST) : '0;
    logic sel;
    assign sel        = wr_en && (addr == ADDR_W'(prot_addr(g)));
    assign prot_we[g] = sel && !locked && (init_mode || !prot_needs_init(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prot_q[g] <= RV;
      else if (prot_we[g]) prot_q[g] <= wdata;
    end
  end

  // init request (protected bit of the status register)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  init_req_q <= 1'b0;
    else if (stat_wr && !locked) init_req_q <= wdata[B_INIT];
  end

  // resync flag: clear by software, set after a four-phase round trip
  assign rsf_clear = stat_wr && !wdata[B_RSF];
  assign rsf_done  = rsf_req_q && hs_ack_bus[HS_RSF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsf_q      <= 1'b0;
      rsf_pend_q <= 1'b0;
      rsf_req_q  <= 1'b0;
    end else begin
      if (rsf_done) begin
        rsf_req_q <= 1'b0;
        rsf_q     <= 1'b1;
      end
      if (rsf_pend_q && !rsf_req_q && !hs_ack_bus[HS_RSF]) begin
        rsf_req_q  <= 1'b1;
        rsf_pend_q <= 1'b0;
      end
      if (rsf_clear) begin
        rsf_q      <= 1'b0;
        rsf_pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_time <= '0;
      shadow_date <= '0;
    end else if (rsf_done) begin
      shadow_time <= prot_q[P_TIME];
      shadow_date <= prot_q[P_DATE];
    end
  end

  assign sync_ok   = rsf_q;
  assign cal_valid = (year_of(32'(prot_q[P_DATE])) != 8'h00);

  always_comb begin
    case (int'(addr))
      A_TIME:  rdata = shadow_time;
      A_DATE:  rdata = shadow_date;
      A_CTRL:  rdata = prot_q[P_CTRL];
      A_PRESC: rdata = prot_q[P_PRESC];
      A_STAT:  rdata = DATA_W'(stat_word(init_req_q, init_mode, rsf_q, cal_valid));
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cal_access_guard_chk.sv
module cal_access_guard_chk
  import cal_acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              locked,
  input logic              init_mode,
  input logic              sync_ok,
  input logic [NPROT-1:0]  prot_we,
  input logic              init_req_q,
  input logic              rsf_req_q
);
  logic key_wr_c, stat_wr_c;
  assign key_wr_c  = wr_en && (addr == ADDR_W'(A_KEY));
  assign stat_wr_c = wr_en && (addr == ADDR_W'(A_STAT));

  a_r1_open_after_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(key_wr_c && wdata[7:0] == KEY_SECOND));

  a_r2_other_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_c && wdata[7:0] != KEY_SECOND) |=> locked);

  a_r4_no_we_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (prot_we == '0));

  a_r5_init_gated_we: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we[P_TIME] || prot_we[P_DATE] || prot_we[P_PRESC]) |-> init_mode);

  a_r5_single_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we));

  a_r6_ack_not_instant: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(init_req_q) && !init_mode) |=> !init_mode);

  a_r7_clear_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_c && !wdata[B_RSF]) |=> !sync_ok);

  a_r7_set_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(rsf_req_q));
endmodule

bind cal_access_guard cal_access_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .locked(locked), .init_mode(init_mode), .sync_ok(sync_ok), .prot_we(prot_we),
  .init_req_q(init_req_q), .rsf_req_q(rsf_req_q)
);

// File: tb/sim_cal_access_guard.sv
module sim_cal_access_guard;
  localparam logic [31:0] PRST = 32'h007F_00FF;
  localparam int AT = 0, AD = 1, AC = 2, AS = 3, AP = 4, AK = 5;

  logic clk = 0, rtc_clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic locked, init_mode, sync_ok, cal_valid;
  logic [3:0] prot_we, last_we;
  int total = 0, passed = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #35 rtc_clk = ~rtc_clk;

  cal_access_guard #(.PRESC_RST(PRST)) u0 (
    .clk(clk), .rtc_clk(rtc_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .locked(locked), .init_mode(init_mode),
    .sync_ok(sync_ok), .cal_valid(cal_valid), .prot_we(prot_we)
  );

  // bench model of the key detector: 0 idle, 1 first key seen, 2 open
  function automatic int key_model(int st, logic [7:0] b);
    if (b == 8'hCA) return 1;
    if (st == 1 && b == 8'h53) return 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = d;
    #1 last_we = prot_we;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    wr_en = 0; addr = 3'(a);
    #1 d = rdata;
  endtask

  // polls sel (0 init_mode, 1 sync_ok) until it equals val; returns cycles taken
  task automatic poll(input int sel, input logic val, output int n);
    n = 0;
    while (((sel == 0) ? init_mode : sync_ok) != val && n < 60) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v, t_new, d_new, p_new, ctrl_m;
    int n, st;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk(locked === 1, "R10 locked", 32'(locked), 1);
    chk(init_mode === 0 && sync_ok === 0, "R10 flags", {30'b0, init_mode, sync_ok}, 0);
    chk(cal_valid === 0, "R9 inits after reset", 32'(cal_valid), 0);
    rd(AP, v); chk(v === PRST, "R10 prescaler reset", v, PRST);
    rd(AK, v); chk(v === 0, "R10 key reads zero", v, 0);

    // R4 locked control write ignored
    wr(AC, 32'hA5A5_0001);
    chk(last_we === 0, "R4 no write enable", 32'(last_we), 0);
    rd(AC, v); chk(v === 0, "R4 control unchanged", v, 0);

    // R3 out-of-order and interrupted sequences
    wr(AK, 32'h53); chk(locked === 1, "R3 second key alone", 32'(locked), 1);
    wr(AK, 32'hCA); wr(AK, 32'hFF); wr(AK, 32'h53);
    chk(locked === 1, "R3 wrong key between", 32'(locked), 1);
    // R1 correct sequence, upper bits ignored
    wr(AK, 32'hFFFF_FFCA); chk(locked === 1, "R1 half way", 32'(locked), 1);
    wr(AK, 32'h1234_5653); chk(locked === 0, "R1 unlocked", 32'(locked), 0);
    // R2 first key while open closes and counts
    wr(AK, 32'hCA); chk(locked === 1, "R2 first key relocks", 32'(locked), 1);
    wr(AK, 32'h53); chk(locked === 0, "R2 first key counted", 32'(locked), 0);

    // random key traffic against the bench model, control as probe
    st = 2; ctrl_m = 0;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      int r;
      r = int'($urandom % 4);
      b = (r == 0) ? 8'hCA : (r == 1) ? 8'h53 : (r == 2) ? 8'hFF : 8'($urandom);
      wr(AK, {24'($urandom), b});
      st = key_model(st, b);
      chk(locked === (st != 2), "R1 R2 R3 random key", 32'(locked), 32'(st != 2));
      v = $urandom;
      wr(AC, v);
      if (st == 2) ctrl_m = v;
      rd(AC, v); chk(v === ctrl_m, "R4 R5 control probe", v, ctrl_m);
    end
    wr(AK, 32'hCA); wr(AK, 32'h53);

    // R5 time and prescaler refused without init
    wr(AT, 32'h0012_3456); chk(last_we === 0, "R5 time needs init", 32'(last_we), 0);
    wr(AP, 32'h0000_0111); rd(AP, v); chk(v === PRST, "R5 presc needs init", v, PRST);

    // R6 init request and acknowledge
    wr(AS, 32'h80);
    poll(0, 1, n);
    chk(n >= 4 && n < 60, "R6 init ack latency", 32'(n), 32'd4);
    rd(AS, v); chk(v[7:6] === 2'b11, "R6 status bits", v, 32'hC0);

    t_new = $urandom & 32'h003F_7F7F;
    d_new = {8'h00, 8'(1 + $urandom % 255), 16'($urandom)};
    p_new = $urandom & 32'h007F_7FFF;
    wr(AT, t_new); chk(last_we === 4'b0001, "R5 time we", 32'(last_we), 1);
    wr(AD, d_new); chk(last_we === 4'b0010, "R5 date we", 32'(last_we), 2);
    chk(cal_valid === 1, "R9 inits nonzero year", 32'(cal_valid), 1);
    wr(AP, p_new); rd(AP, v); chk(v === p_new, "R5 presc in init", v, p_new);
    rd(AT, v); chk(v === 0, "R8 shadow still old", v, 0);

    // R6 leave init; same write clears the resync flag (R7)
    wr(AS, 32'h00);
    chk(sync_ok === 0, "R7 cleared", 32'(sync_ok), 0);
    poll(0, 0, n);
    chk(n >= 4 && n < 60, "R6 init ack release", 32'(n), 32'd4);
    poll(1, 1, n);
    chk(sync_ok === 1, "R7 resync set", 32'(sync_ok), 1);
    rd(AT, v); chk(v === t_new, "R8 shadow time", v, t_new);
    rd(AD, v); chk(v === d_new, "R8 shadow date", v, d_new);

    // R7 writing 1 has no effect
    wr(AS, 32'h20); chk(sync_ok === 1, "R7 write one no effect", 32'(sync_ok), 1);

    // R2 wrong key relocks at once
    wr(AK, 32'hFF); chk(locked === 1, "R2 relock", 32'(locked), 1);
    // R7 clear works while locked
    wr(AS, 32'h00); chk(sync_ok === 0, "R7 clear while locked", 32'(sync_ok), 0);
    poll(1, 1, n);
    chk(n >= 4 && n < 60, "R7 round trip", 32'(n), 32'd4);
    // R4 init request ignored while locked
    wr(AS, 32'hA0);
    repeat (40) @(negedge clk);
    chk(init_mode === 0, "R4 init ignored", 32'(init_mode), 0);
    rd(AS, v); chk(v[7] === 1'b0, "R4 init bit stays", v, 32'h30);
    wr(AC, 32'h7); chk(last_we === 0, "R4 control locked", 32'(last_we), 0);

    // R9 zero year clears the valid flag
    wr(AK, 32'hCA); wr(AK, 32'h53);
    wr(AS, 32'hA0); poll(0, 1, n);
    wr(AD, d_new & 32'hFF00_FFFF);
    chk(cal_valid === 0, "R9 zero year", 32'(cal_valid), 0);
    wr(AS, 32'h20); poll(0, 0, n);
    chk(init_mode === 0, "R6 exit again", 32'(init_mode), 0);

    finish_run();
  end
endmodule